// File: doc/BRIEF.md
# SD Card Host Transfer Status Tracker

This block keeps the transfer status word on the host side of an MMC/SD card link. The command engine, the data engine and the register file each send it single-cycle strobes. From these strobes it keeps five event flags. It also watches the card's DAT0 line, so the host can tell when a card that held DAT0 low during a block write has a free receive buffer again.

The status word is an 8-bit vector that the register file returns to software. Reading it clears the block-end flag. The other flags are set and cleared by their own events. When a set event and a clear event for the same flag land in the same cycle, the set wins, so no event is lost. Every flag is held in a register, so a strobe sampled at clock edge n shows on the status word after edge n.

Top module: `sd_status_tracker`

## Requirements
- R1: After a synchronous active-low reset the status word reads 8'h25. Command-ready (bit 0), transmit-ready (bit 2) and card-not-busy (bit 5) are 1. All other bits are 0.
- R2: Bits 7:6 of the status word always read 0.
- R3: Command-ready (bit 0) is set by `cmd_sent` and cleared by `cmd_reg_wr`. If both come in the same cycle, the set wins.
- R4: Receive-ready (bit 1) is set by `rx_word_in` and cleared by `rx_reg_rd`. If both come in the same cycle, the set wins.
- R5: Transmit-ready (bit 2) is set by `tx_word_out` and cleared by `tx_reg_wr`. If both come in the same cycle, the set wins.
- R6: Block-end (bit 3) is set once for every `crc_token` strobe and cleared by `status_rd`. If both come in the same cycle, the set wins.
- R7: Transfer-active (bit 4) is set by `xfer_start` and cleared by `crc16_done`. If both come in the same cycle, the set wins.
- R8: Card-not-busy (bit 5) goes to 0 in the cycle after `rsp_end`. Another `rsp_end` clears it again.
- R9: DAT0 passes through a two-flop synchroniser that resets to high. After `rsp_end`, card-not-busy is set at the first later edge where the synchronised DAT0 is high. A high level sampled on `dat0` at edge e sets card-not-busy at edge e+2. While card-not-busy is 1, DAT0 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat0 | input | 1 | Card DAT0 line, asynchronous to clk |
| cmd_sent | input | 1 | Strobe: the last command has been sent |
| rsp_end | input | 1 | Strobe: the card response has ended |
| xfer_start | input | 1 | Strobe: a data transfer begins |
| crc16_done | input | 1 | Strobe: the CRC16 calculation for the transfer has finished |
| crc_token | input | 1 | Strobe: a CRC status token was received after a written block |
| tx_word_out | input | 1 | Strobe: the last transmit word has been sent |
| rx_word_in | input | 1 | Strobe: a new receive word has arrived |
| status_rd | input | 1 | Strobe: software reads the status word |
| cmd_reg_wr | input | 1 | Strobe: software writes the command register |
| tx_reg_wr | input | 1 | Strobe: software writes the transmit data register |
| rx_reg_rd | input | 1 | Strobe: software reads the receive data register |
| status | output | 8 | Status word |

## Verification
Random strobes are driven with about one chance in four per input per cycle. This mix covers lone sets, lone clears and set/clear collisions for every flag, and it tells a set-wins design apart from a clear-wins one. DAT0 flips rarely, so its long low and high stretches show whether the busy flag waits for release and whether it honours the two-stage synchroniser delay. Directed runs check three cases: a response that ends while DAT0 is held low, a release timed to the exact edge, and a block-end that collides with a status read.

// File: rtl/sdst_pkg.sv
// Shared constants for the SD status tracker: status bit positions and reset image.
package sdst_pkg;
    localparam int STATUS_W   = 8;
    localparam int NUM_EVFLAG = 5;     // flags driven purely by set/clear strobes
    localparam int B_CMDRDY   = 0;
    localparam int B_RXRDY    = 1;
    localparam int B_TXRDY    = 2;
    localparam int B_BLKEND   = 3;
    localparam int B_XFERACT  = 4;
    localparam int B_NOTBUSY  = 5;
    // Reset values of the event flags, indexed by bit position 0..4.
    localparam logic [NUM_EVFLAG-1:0] EVFLAG_RST = 5'b00101;
endpackage

// File: rtl/sdst_sync.sv
// Multi-stage synchroniser for an asynchronous level.
// Assumes: the input is a slow level; the chain resets to RST_VAL.
module sdst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdst_flag.sv
// One status flag with a set strobe and a clear strobe; set has priority.
// Assumes: strobes are one cycle wide and synchronous to clk.
module sdst_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Update the flag; set beats clear so no event is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/sdst_busy.sv
// Card-not-busy tracker: cleared at response end, then set once the
// synchronised DAT0 is seen high (card has released the busy hold).
// Assumes: dat_hi is already synchronised to clk.
module sdst_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic dat_hi,
    input  logic rsp_end,
    output logic notbusy
);
    logic armed;

    // Arm on response end; release when DAT0 reads high while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            notbusy <= 1'b1;
        end else if (rsp_end) begin
            armed   <= 1'b1;
            notbusy <= 1'b0;
        end else if (armed && dat_hi) begin
            armed   <= 1'b0;
            notbusy <= 1'b1;
        end
    end

    // R8: a response end always drops the flag on the next edge
    assert_rsp_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_end |=> !notbusy);
    // R9: armed and line released without a new response sets the flag
    assert_release_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dat_hi && !rsp_end) |=> notbusy);
    // R9: a set flag never drops without a response end
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (notbusy && !rsp_end) |=> notbusy);
endmodule

// File: rtl/sd_status_tracker.sv
// SD host status tracker top: five event flags plus the DAT0 busy tracker,
// packed into an 8-bit status word.
// Assumes: all strobes are single-cycle pulses in the clk domain; dat0 is async.
module sd_status_tracker
    import sdst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dat0,
    input  logic                cmd_sent,
    input  logic                rsp_end,
    input  logic                xfer_start,
    input  logic                crc16_done,
    input  logic                crc_token,
    input  logic                tx_word_out,
    input  logic                rx_word_in,
    input  logic                status_rd,
    input  logic                cmd_reg_wr,
    input  logic                tx_reg_wr,
    input  logic                rx_reg_rd,
    output logic [STATUS_W-1:0] status
);
    localparam int PAD_W = STATUS_W - NUM_EVFLAG - 1;

    logic [NUM_EVFLAG-1:0] set_v, clr_v, flag_q;
    logic dat_hi, notbusy;

    // Route event strobes to their flag slots by bit position.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[B_CMDRDY]  = cmd_sent;    clr_v[B_CMDRDY]  = cmd_reg_wr;
        set_v[B_RXRDY]   = rx_word_in;  clr_v[B_RXRDY]   = rx_reg_rd;
        set_v[B_TXRDY]   = tx_word_out; clr_v[B_TXRDY]   = tx_reg_wr;
        set_v[B_BLKEND]  = crc_token;   clr_v[B_BLKEND]  = status_rd;
        set_v[B_XFERACT] = xfer_start;  clr_v[B_XFERACT] = crc16_done;
    end

    for (genvar i = 0; i < NUM_EVFLAG; i++) begin : g_flag
        sdst_flag #(.RST_VAL(EVFLAG_RST[i])) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set(set_v[i]), .clr(clr_v[i]), .q(flag_q[i])
        );
    end

    sdst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(dat0), .q(dat_hi)
    );

    sdst_busy u_busy (
        .clk(clk), .rst_n(rst_n), .dat_hi(dat_hi),
        .rsp_end(rsp_end), .notbusy(notbusy)
    );

    assign status = {{PAD_W{1'b0}}, notbusy, flag_q};

    // R2: upper bits read zero
    always_comb assert_pad_zero_R2: assert (status[STATUS_W-1:B_NOTBUSY+1] == '0);
    // R1: first cycle after reset shows the idle image
    assert_reset_image_R1: assert property (@(posedge clk)
        !rst_n |=> status == 8'h25);
    // R3: command write without a send clears command-ready
    assert_cmd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reg_wr && !cmd_sent) |=> !status[B_CMDRDY]);
    // R6: every CRC token leaves block-end set, even against a status read
    assert_blk_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_token |=> status[B_BLKEND]);
    // R6: a status read without a token clears block-end
    assert_blk_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !crc_token) |=> !status[B_BLKEND]);
    // R7: transfer start raises transfer-active
    assert_xfer_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> status[B_XFERACT]);
    // R4: a receive word raises receive-ready
    assert_rx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_in |=> status[B_RXRDY]);
    // R5: a transmit write without a send clears transmit-ready
    assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_reg_wr && !tx_word_out) |=> !status[B_TXRDY]);
endmodule

// File: tb/sim_sd_status_tracker.sv
module sim_sd_status_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dat0 = 1'b1;
    logic cmd_sent = 0, rsp_end = 0, xfer_start = 0, crc16_done = 0, crc_token = 0;
    logic tx_word_out = 0, rx_word_in = 0, status_rd = 0, cmd_reg_wr = 0;
    logic tx_reg_wr = 0, rx_reg_rd = 0;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected model state
    logic [7:0] exp_st;
    logic       m_armed;
    logic [1:0] m_sync;

    always #5 clk = ~clk;

    sd_status_tracker u0 (
        .clk(clk), .rst_n(rst_n), .dat0(dat0),
        .cmd_sent(cmd_sent), .rsp_end(rsp_end), .xfer_start(xfer_start),
        .crc16_done(crc16_done), .crc_token(crc_token),
        .tx_word_out(tx_word_out), .rx_word_in(rx_word_in),
        .status_rd(status_rd), .cmd_reg_wr(cmd_reg_wr),
        .tx_reg_wr(tx_reg_wr), .rx_reg_rd(rx_reg_rd), .status(status)
    );

    function automatic logic nxt(input logic q, input logic s, input logic c);
        return s ? 1'b1 : (c ? 1'b0 : q);
    endfunction

    function automatic string req_of(input int b);
        case (b)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8/R9";
            default: return "R2";
        endcase
    endfunction

    task automatic model_reset();
        exp_st = 8'h25; m_armed = 1'b0; m_sync = 2'b11;
    endtask

    // Advance the model by one edge with the currently driven inputs.
    task automatic model_step();
        logic nb;
        nb = exp_st[5];
        if (rsp_end) begin nb = 1'b0; m_armed = 1'b1; end
        else if (m_armed && m_sync[1]) begin nb = 1'b1; m_armed = 1'b0; end
        exp_st[0] = nxt(exp_st[0], cmd_sent,    cmd_reg_wr);
        exp_st[1] = nxt(exp_st[1], rx_word_in,  rx_reg_rd);
        exp_st[2] = nxt(exp_st[2], tx_word_out, tx_reg_wr);
        exp_st[3] = nxt(exp_st[3], crc_token,   status_rd);
        exp_st[4] = nxt(exp_st[4], xfer_start,  crc16_done);
        exp_st[5] = nb;
        m_sync = {m_sync[0], dat0};
    endtask

    task automatic check_all(input string tag);
        for (int b = 0; b < 8; b++) begin
            checks++;
            if (status[b] !== exp_st[b]) begin
                errors++;
                $display("FAIL %s bit%0d (%s): actual %b expected %b", req_of(b), b, tag,
                         status[b], exp_st[b]);
            end
        end
    endtask

    task automatic clear_in();
        {cmd_sent, rsp_end, xfer_start, crc16_done, crc_token, tx_word_out,
         rx_word_in, status_rd, cmd_reg_wr, tx_reg_wr, rx_reg_rd} = '0;
    endtask

    // One cycle: drive at negedge, clock, update model, check at next negedge.
    task automatic cycle(input string tag);
        @(posedge clk); #1;
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (status !== 8'h25) begin
            errors++;
            $display("FAIL R1 reset word: actual %h expected 25", status);
        end

        // R8/R9 directed: response end while card holds DAT0 low
        clear_in(); dat0 = 1'b0; cycle("hold low");
        cycle("hold low");
        rsp_end = 1'b1; cycle("rsp_end busy R8");
        clear_in();
        repeat (5) cycle("busy stays R9");
        dat0 = 1'b1; cycle("release edge e R9");
        clear_in(); cycle("release e+1 R9");
        cycle("release e+2 R9");
        checks++;
        if (status[5] !== 1'b1) begin
            errors++;
            $display("FAIL R9 not-busy at e+2: actual %b expected 1", status[5]);
        end
        // R9: DAT0 low while not busy has no effect
        dat0 = 1'b0; repeat (4) cycle("dat0 ignored R9");
        dat0 = 1'b1; repeat (2) cycle("settle");

        // R6 directed: token and status read collide; then lone read
        crc_token = 1'b1; status_rd = 1'b1; cycle("blk collide R6");
        clear_in(); status_rd = 1'b1; cycle("blk read R6");
        clear_in(); crc_token = 1'b1; cycle("blk token R6");
        crc_token = 1'b1; cycle("blk second token R6");
        clear_in();

        // R3/R4/R5/R7 collisions
        cmd_sent = 1; cmd_reg_wr = 1; rx_word_in = 1; rx_reg_rd = 1;
        tx_word_out = 1; tx_reg_wr = 1; xfer_start = 1; crc16_done = 1;
        cycle("all collide R3 R4 R5 R7");
        clear_in(); cmd_reg_wr = 1; rx_reg_rd = 1; tx_reg_wr = 1; crc16_done = 1;
        cycle("all clear R3 R4 R5 R7");
        clear_in();

        // Constrained random
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            cmd_sent    = ($urandom % 4) == 0;
            rsp_end     = ($urandom % 12) == 0;
            xfer_start  = ($urandom % 4) == 0;
            crc16_done  = ($urandom % 4) == 0;
            crc_token   = ($urandom % 4) == 0;
            tx_word_out = ($urandom % 4) == 0;
            rx_word_in  = ($urandom % 4) == 0;
            status_rd   = ($urandom % 4) == 0;
            cmd_reg_wr  = ($urandom % 4) == 0;
            tx_reg_wr   = ($urandom % 4) == 0;
            rx_reg_rd   = ($urandom % 4) == 0;
            if (($urandom % 10) == 0) dat0 = ~dat0;
            cycle("random");
        end
        clear_in();
        done = 1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule